// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state of a small table of interrupt sources (16 by default) and decides when each source should be offered to a presentation unit. Each entry holds a destination server index, a live priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. The source type is fixed by a parameter mask. A set bit makes a source level-type. A clear bit makes it message-type. The priority value 0xFF means masked.

The block has four inputs and outputs besides clock and reset:
- Source lines: one line per source comes in. A level source tracks the line. A message source fires on a rising edge of its line.
- Notifications: the presentation unit sends reject, end-of-interrupt and resend notifications on a notification port.
- Commands: a configuration port accepts four commands. Route-write sets server and both priorities. Route-read returns server and priority. Mask-off and mask-on are the other two.
- Offers: offers leave through a single-entry port that has a valid/ready handshake.

Global source numbers are the table index plus the parameter `BASE`. Commands that name a number outside the table, a server index that does not exist, or a priority wider than 8 bits are refused.

Top module: `intr_source_ctrl`

## Requirements
- R1: After reset, every source has priority 0xFF, saved priority 0xFF, server 0 and all status flags clear. No offer is valid. A route-read of any source returns priority 0xFF and server 0 with no error.
- R2: A rising edge on a message source line behaves as follows. If the source is unmasked, it raises one offer carrying number BASE+index, its server and its priority. If the source is masked, it raises no offer and instead records masked-pending.
- R3: The asserted flag of a level source follows its line. A level source that is unmasked, asserted and not sent sets sent and raises one offer. While sent stays set, it raises no further offer.
- R4: A reject notification (kind 0) addressed to a source sets its rejected flag and clears its sent flag. For a level source whose line is still high, the next resend therefore offers it again.
- R5: A resend notification (kind 2) ignores its number and visits every source. A level source is re-evaluated as in R3. A rejected message source has rejected cleared and is offered again if unmasked, so a second resend with no new reject gives no offer.
- R6: An end-of-interrupt notification (kind 1) clears sent on a level source and raises no offer by itself. On a message source it changes nothing, which a following resend shows.
- R7: Route-write (command op 0) stores server, priority and saved priority. A message source with masked-pending that becomes unmasked clears masked-pending and is offered. A level source is re-evaluated as in R3.
- R8: Mask-off (op 2) copies the priority into the saved priority and sets the priority to 0xFF. Mask-on (op 3) copies the saved priority into the priority. A message trigger recorded while off is offered when mask-on unmasks the source.
- R9: A command whose number lies outside [BASE, BASE+N) is refused with an error and changes nothing. A route-write whose server is at or above N_SERVERS, or whose 9-bit priority is above 0xFF, is also refused with an error and changes nothing. Notification kind 3 is ignored.
- R10: When several sources are waiting, the offer port presents the lowest index first. A presented offer stays valid with the same number until accepted. Each event gives exactly one offer.
- R11: Each command produces a response in the next cycle. Route-read (op 1) returns the stored server and priority of the addressed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | N_SRC | Source lines, one per table entry |
| ntf_valid | input | 1 | Notification strobe |
| ntf_kind | input | 2 | 0 reject, 1 end-of-interrupt, 2 resend, 3 ignored |
| ntf_num | input | NUM_W | Global source number for reject and end-of-interrupt |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 route-write, 1 route-read, 2 mask-off, 3 mask-on |
| cmd_num | input | NUM_W | Global source number |
| cmd_server | input | SRV_IN_W | Destination server for route-write |
| cmd_prio | input | 9 | Priority for route-write (values above 0xFF are refused) |
| rsp_valid | output | 1 | Response strobe, one cycle after cmd_valid |
| rsp_err | output | 1 | Parameter error |
| rsp_server | output | SRV_W | Server returned by route-read |
| rsp_prio | output | 8 | Priority returned by route-read |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Presentation unit takes the offer |
| offer_num | output | NUM_W | Global number of the offered source |
| offer_server | output | SRV_W | Destination server of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The hardest state to reach is a level source that has already been offered and whose line stays high. The flags cannot be observed directly, so the sent flag can only be seen through which of the later resends produce a new offer. The bench reaches it by holding the line high across a series of notifications: resend alone, then end-of-interrupt followed by resend, then reject followed by resend. It accepts each offer in between, so every renewed offer can be traced to the notification that cleared sent. A second hard case, two triggers in the same cycle with ready held low, checks that the port holds its choice and then drains in index order.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    CMD_ROUTE_WR = 2'd0,
    CMD_ROUTE_RD = 2'd1,
    CMD_MASK_OFF = 2'd2,
    CMD_MASK_ON  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    NTF_REJECT = 2'd0,
    NTF_EOI    = 2'd1,
    NTF_RESEND = 2'd2,
    NTF_NONE   = 2'd3
  } ntf_kind_e;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } src_status_t;

  // number lies inside [base, base+count)
  function automatic logic num_in_table(input int unsigned num,
                                        input int unsigned base,
                                        input int unsigned count);
    return (num >= base) && (num < base + count);
  endfunction

  // a level source should be offered now
  function automatic logic level_fire(input logic [PRIO_W-1:0] prio,
                                      input src_status_t st);
    return (prio != PRIO_MASKED) && st.asserted && !st.sent;
  endfunction
endpackage

// File: rtl/isc_cmd_check.sv
module isc_cmd_check
  import isc_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int BASE      = 4096,
  parameter int N_SERVERS = 4,
  parameter int NUM_W     = 16,
  parameter int SRV_IN_W  = 8,
  localparam int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [1:0]          cmd_op,
  input  logic [NUM_W-1:0]    cmd_num,
  input  logic [SRV_IN_W-1:0] cmd_server,
  input  logic [8:0]          cmd_prio,
  input  logic [NUM_W-1:0]    ntf_num,
  output logic                cmd_err,
  output logic [IDX_W-1:0]    cmd_idx,
  output logic                ntf_ok,
  output logic [IDX_W-1:0]    ntf_idx
);
  logic cmd_num_ok, route_bad;

  always_comb begin
    cmd_num_ok = num_in_table(32'(cmd_num), BASE, N_SRC);
    route_bad  = (cmd_op == CMD_ROUTE_WR) &&
                 ((32'(cmd_server) >= N_SERVERS) || (cmd_prio > 9'h0FF));
    cmd_err    = !cmd_num_ok || route_bad;
    cmd_idx    = IDX_W'(cmd_num - NUM_W'(BASE));
    ntf_ok     = num_in_table(32'(ntf_num), BASE, N_SRC);
    ntf_idx    = IDX_W'(ntf_num - NUM_W'(BASE));
  end
endmodule

// File: rtl/isc_source_slot.sv
module isc_source_slot
  import isc_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0,
  parameter int SRV_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              ntf_hit,
  input  logic [1:0]        ntf_kind,
  input  logic              resend,
  input  logic              cmd_hit,
  input  logic [1:0]        cmd_op,
  input  logic [SRV_W-1:0]  cmd_server,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic              grant,
  output logic              pend,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio
);
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic [PRIO_W-1:0] prio_q, prio_d, saved_q, saved_d;
  src_status_t       st_q, st_d;
  logic              line_q, pend_q, offer_evt;

  always_comb begin
    srv_d = srv_q;
    prio_d = prio_q;
    saved_d = saved_q;
    st_d = st_q;
    offer_evt = 1'b0;

    // line event
    if (IS_LEVEL) begin
      if (line_in != line_q) begin
        st_d.asserted = line_in;
        if (level_fire(prio_d, st_d)) begin
          st_d.sent = 1'b1;
          offer_evt = 1'b1;
        end
      end
    end else if (line_in && !line_q) begin
      if (prio_d == PRIO_MASKED) st_d.mpend = 1'b1;
      else offer_evt = 1'b1;
    end

    // addressed notifications
    if (ntf_hit) begin
      if (ntf_kind == NTF_REJECT) begin
        st_d.rejected = 1'b1;
        st_d.sent = 1'b0;
      end else if (ntf_kind == NTF_EOI && IS_LEVEL) begin
        st_d.sent = 1'b0;
      end
    end

    // broadcast resend
    if (resend) begin
      if (IS_LEVEL) begin
        if (level_fire(prio_d, st_d)) begin
          st_d.sent = 1'b1;
          offer_evt = 1'b1;
        end
      end else if (st_d.rejected) begin
        st_d.rejected = 1'b0;
        if (prio_d != PRIO_MASKED) offer_evt = 1'b1;
      end
    end

    // configuration
    if (cmd_hit && cmd_op != CMD_ROUTE_RD) begin
      case (cmd_op)
        CMD_ROUTE_WR: begin
          srv_d = cmd_server;
          prio_d = cmd_prio;
          saved_d = cmd_prio;
        end
        CMD_MASK_OFF: begin
          saved_d = prio_d;
          prio_d = PRIO_MASKED;
        end
        default: prio_d = saved_d;
      endcase
      if (IS_LEVEL) begin
        if (level_fire(prio_d, st_d)) begin
          st_d.sent = 1'b1;
          offer_evt = 1'b1;
        end
      end else if (st_d.mpend && prio_d != PRIO_MASKED) begin
        st_d.mpend = 1'b0;
        offer_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srv_q   <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
      st_q    <= '0;
      line_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      saved_q <= saved_d;
      st_q    <= st_d;
      line_q  <= line_in;
      pend_q  <= (pend_q && !grant) || offer_evt;
    end
  end

  assign pend   = pend_q;
  assign server = srv_q;
  assign prio   = prio_q;

  AST_MPEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.mpend |-> prio_q == PRIO_MASKED);  // R2
  AST_MSG_NEVER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_LEVEL |-> !st_q.sent);  // R3
  AST_SENT_RISE_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.sent) |-> pend_q);  // R3
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb #(
  parameter int N_SRC  = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic             offer_ready,
  output logic             offer_valid,
  output logic [IDX_W-1:0] sel,
  output logic [N_SRC-1:0] grant
);
  logic [IDX_W-1:0] low_idx, sel_q;
  logic             lock_q;

  always_comb begin
    low_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = IDX_W'(i);
    end
    offer_valid = |pend;
    sel = lock_q ? sel_q : low_idx;
    grant = '0;
    if (offer_valid && offer_ready) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      lock_q <= offer_valid && !offer_ready;
      sel_q  <= sel;
    end
  end

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(sel));  // R10
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R10
endmodule

// File: rtl/intr_source_ctrl.sv
module intr_source_ctrl
  import isc_pkg::*;
#(
  parameter int                N_SRC      = 16,
  parameter int                BASE       = 4096,
  parameter int                N_SERVERS  = 4,
  parameter int                NUM_W      = 16,
  parameter int                SRV_IN_W   = 8,
  parameter logic [N_SRC-1:0]  LEVEL_MASK = 16'hFF00,
  localparam int               SRV_W      = (N_SERVERS > 1) ? $clog2(N_SERVERS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_line,
  input  logic                ntf_valid,
  input  logic [1:0]          ntf_kind,
  input  logic [NUM_W-1:0]    ntf_num,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [NUM_W-1:0]    cmd_num,
  input  logic [SRV_IN_W-1:0] cmd_server,
  input  logic [8:0]          cmd_prio,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [SRV_W-1:0]    rsp_server,
  output logic [7:0]          rsp_prio,
  output logic                offer_valid,
  input  logic                offer_ready,
  output logic [NUM_W-1:0]    offer_num,
  output logic [SRV_W-1:0]    offer_server,
  output logic [7:0]          offer_prio
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             cmd_err, ntf_ok, resend_all;
  logic [IDX_W-1:0] cmd_idx, ntf_idx, sel;
  logic [N_SRC-1:0] pend_vec, grant_vec;
  logic [SRV_W-1:0] srv_arr  [N_SRC];
  logic [7:0]       prio_arr [N_SRC];

  isc_cmd_check #(
    .N_SRC(N_SRC), .BASE(BASE), .N_SERVERS(N_SERVERS),
    .NUM_W(NUM_W), .SRV_IN_W(SRV_IN_W)
  ) u_check (
    .cmd_op(cmd_op), .cmd_num(cmd_num), .cmd_server(cmd_server),
    .cmd_prio(cmd_prio), .ntf_num(ntf_num), .cmd_err(cmd_err),
    .cmd_idx(cmd_idx), .ntf_ok(ntf_ok), .ntf_idx(ntf_idx)
  );

  assign resend_all = ntf_valid && (ntf_kind == NTF_RESEND);

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    isc_source_slot #(.IS_LEVEL(LEVEL_MASK[g]), .SRV_W(SRV_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .line_in(src_line[g]),
      .ntf_hit(ntf_valid && ntf_ok && ntf_idx == IDX_W'(g)),
      .ntf_kind(ntf_kind), .resend(resend_all),
      .cmd_hit(cmd_valid && !cmd_err && cmd_idx == IDX_W'(g)),
      .cmd_op(cmd_op), .cmd_server(SRV_W'(cmd_server)),
      .cmd_prio(cmd_prio[7:0]), .grant(grant_vec[g]),
      .pend(pend_vec[g]), .server(srv_arr[g]), .prio(prio_arr[g])
    );
  end

  isc_offer_arb #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend_vec), .offer_ready(offer_ready),
    .offer_valid(offer_valid), .sel(sel), .grant(grant_vec)
  );

  assign offer_num    = NUM_W'(BASE) + NUM_W'(sel);
  assign offer_server = srv_arr[sel];
  assign offer_prio   = prio_arr[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_err    <= cmd_valid && cmd_err;
      rsp_server <= '0;
      rsp_prio   <= '0;
      if (cmd_valid && !cmd_err && cmd_op == CMD_ROUTE_RD) begin
        rsp_server <= srv_arr[cmd_idx];
        rsp_prio   <= prio_arr[cmd_idx];
      end
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);  // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);  // R11
  AST_BAD_NUM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (32'(cmd_num) < BASE || 32'(cmd_num) >= BASE + N_SRC)
    |=> rsp_err);  // R9
  AST_NO_OFFER_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !offer_valid);  // R1
endmodule

// File: tb/intr_source_ctrl_tb.sv
module intr_source_ctrl_tb;
  localparam int BASE = 4096;
  localparam int NS   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_line = '0;
  logic        ntf_valid = 1'b0;
  logic [1:0]  ntf_kind = 2'd3;
  logic [15:0] ntf_num = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_num = '0;
  logic [7:0]  cmd_server = '0;
  logic [8:0]  cmd_prio = '0;
  logic        rsp_valid, rsp_err, offer_valid;
  logic        offer_ready = 1'b0;
  logic [1:0]  rsp_server, offer_server;
  logic [7:0]  rsp_prio, offer_prio;
  logic [15:0] offer_num;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_source_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_line(src_line),
    .ntf_valid(ntf_valid), .ntf_kind(ntf_kind), .ntf_num(ntf_num),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_server(cmd_server), .cmd_prio(cmd_prio),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_server(rsp_server),
    .rsp_prio(rsp_prio), .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_num(offer_num), .offer_server(offer_server), .offer_prio(offer_prio)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input int idx, input int srv,
                          input int prio, input string req, input int exp_err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_num = 16'(BASE + idx);
    cmd_server = 8'(srv); cmd_prio = 9'(prio);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(req, "rsp_valid", int'(rsp_valid), 1);
    check(req, "rsp_err", int'(rsp_err), exp_err);
  endtask

  task automatic read_route(input int idx, input int exp_srv, input int exp_prio,
                            input string req);
    send_cmd(2'd1, idx, 0, 0, req, 0);
    check(req, "read server", int'(rsp_server), exp_srv);
    check(req, "read prio", int'(rsp_prio), exp_prio);
  endtask

  task automatic notify(input logic [1:0] kind, input int idx);
    @(negedge clk);
    ntf_valid = 1'b1; ntf_kind = kind; ntf_num = 16'(BASE + idx);
    @(negedge clk);
    ntf_valid = 1'b0; ntf_kind = 2'd3;
  endtask

  task automatic pulse_line(input int idx);
    @(negedge clk);
    src_line[idx] = 1'b1;
    @(negedge clk);
    src_line[idx] = 1'b0;
  endtask

  task automatic set_line(input int idx, input logic v);
    @(negedge clk);
    src_line[idx] = v;
    @(negedge clk);
  endtask

  task automatic expect_offer(input int idx, input int srv, input int prio,
                              input string req);
    check(req, "offer_valid", int'(offer_valid), 1);
    check(req, "offer_num", int'(offer_num), BASE + idx);
    check(req, "offer_server", int'(offer_server), srv);
    check(req, "offer_prio", int'(offer_prio), prio);
    offer_ready = 1'b1;
    @(negedge clk);
    offer_ready = 1'b0;
  endtask

  task automatic expect_quiet(input string req);
    check(req, "no offer", int'(offer_valid), 0);
  endtask

  task automatic t_reset;
    expect_quiet("R1");
    check("R1", "rsp_valid idle", int'(rsp_valid), 0);
    read_route(0, 0, 255, "R1");
    read_route(15, 0, 255, "R1");
  endtask

  task automatic t_errors;
    send_cmd(2'd1, -1, 0, 0, "R9", 1);
    send_cmd(2'd2, NS, 0, 0, "R9", 1);
    send_cmd(2'd0, 0, 4, 1, "R9", 1);
    send_cmd(2'd0, 0, 1, 9'h100, "R9", 1);
    read_route(0, 0, 255, "R9");
    notify(2'd3, 0);
    expect_quiet("R9");
  endtask

  task automatic t_message;
    pulse_line(2);
    expect_quiet("R2");
    send_cmd(2'd0, 2, 1, 5, "R7", 0);
    expect_offer(2, 1, 5, "R7");
    expect_quiet("R7");
    pulse_line(2);
    expect_offer(2, 1, 5, "R2");
    notify(2'd0, 2);
    expect_quiet("R4");
    notify(2'd2, 0);
    expect_offer(2, 1, 5, "R5");
    notify(2'd2, 0);
    expect_quiet("R5");
    notify(2'd1, 2);
    notify(2'd2, 0);
    expect_quiet("R6");
  endtask

  task automatic t_level;
    send_cmd(2'd0, 9, 2, 3, "R7", 0);
    expect_quiet("R3");
    set_line(9, 1'b1);
    expect_offer(9, 2, 3, "R3");
    notify(2'd2, 0);
    expect_quiet("R3");
    notify(2'd1, 9);
    expect_quiet("R6");
    notify(2'd2, 0);
    expect_offer(9, 2, 3, "R6");
    notify(2'd0, 9);
    notify(2'd2, 0);
    expect_offer(9, 2, 3, "R4");
    set_line(9, 1'b0);
    notify(2'd1, 9);
    notify(2'd2, 0);
    expect_quiet("R3");
    set_line(10, 1'b1);
    expect_quiet("R3");
    send_cmd(2'd0, 10, 0, 2, "R7", 0);
    expect_offer(10, 0, 2, "R7");
    set_line(10, 1'b0);
  endtask

  task automatic t_mask;
    send_cmd(2'd0, 4, 3, 7, "R8", 0);
    expect_quiet("R8");
    send_cmd(2'd2, 4, 0, 0, "R8", 0);
    read_route(4, 3, 255, "R8");
    pulse_line(4);
    expect_quiet("R8");
    send_cmd(2'd3, 4, 0, 0, "R8", 0);
    expect_offer(4, 3, 7, "R8");
    read_route(4, 3, 7, "R11");
  endtask

  task automatic t_order;
    send_cmd(2'd0, 3, 0, 1, "R10", 0);
    send_cmd(2'd0, 5, 1, 2, "R10", 0);
    @(negedge clk);
    src_line[3] = 1'b1; src_line[5] = 1'b1;
    @(negedge clk);
    src_line[3] = 1'b0; src_line[5] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10", "held valid", int'(offer_valid), 1);
      check("R10", "held num", int'(offer_num), BASE + 3);
      @(negedge clk);
    end
    expect_offer(3, 0, 1, "R10");
    expect_offer(5, 1, 2, "R10");
    expect_quiet("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_errors;
    t_message;
    t_level;
    t_mask;
    t_order;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule